// File: doc/BRIEF.md
# First-Failure Datalog Capture Unit

This unit sits beside a memory self-test engine and watches every read comparison the engine makes. On each strobed compare it forms the difference between the read word and the expected word, drops the bit positions configured as unused, and treats any remaining difference as a miscompare. It drives a fail flag that either stays up from the first miscompare onward or pulses on each miscompare cycle, depending on a fail-mode bit.

At the first miscompare the unit freezes a set of diagnostic fields: the physical address, the masked difference word, the data seed in effect at that moment, the algorithm pass number, the pattern code and which half of the wide read held the failure. Those fields then hold until a clear. A per-memory failure bitmap keeps accumulating over the whole run. Two designated memories that the engine can test together share their failures in that bitmap. The test patterns themselves are generated elsewhere.

Top module: `ffail_log`

## Requirements
- R1: After reset or a cycle with `clr` high, `fail`, `fail_map` and every log field read 0. Reset also puts the fail mode to sticky (mode bit 0).
- R2: A miscompare is a cycle with `cmp_valid` high and a nonzero value of (`rd_data` XOR `exp_data`) AND `bit_mask`. A bit with `bit_mask` 0 never produces a failure.
- R3: In sticky mode (mode bit 0), `fail` rises on the clock edge that samples the first miscompare and stays high until `clr` or reset.
- R4: In real-time mode (mode bit 1), `fail` is high in the cycle after each miscompare cycle and low in the cycle after any other cycle.
- R5: `log_addr`, `log_seed`, `log_pass`, `log_pattern` and `log_bits` hold the values of the first miscompare after reset or clear, with `log_bits` equal to the masked XOR. Later miscompares leave them unchanged.
- R6: Each miscompare sets bit `mem_idx` of `fail_map`. Set bits stay set, so several bits can be set during one run.
- R7: With `pair_en` high, a miscompare whose `mem_idx` is either of the two paired memories (default indices 3 and 4) sets both of their bits in `fail_map`.
- R8: `log_half` logs 0 when the first miscompare has a failing bit anywhere in bits 31:0, and 1 when its failing bits all lie in bits 64:32.
- R9: A cycle with `mode_wr` high loads `mode_rt` into the fail-mode bit, and the new mode applies from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clr | input | 1 | Synchronous clear of the log, bitmap and fail flag |
| mode_wr | input | 1 | Load strobe for the fail-mode bit |
| mode_rt | input | 1 | Fail mode to load: 1 real-time, 0 sticky |
| pair_en | input | 1 | Paired memories are under test in parallel |
| cmp_valid | input | 1 | Read comparison strobe |
| rd_data | input | 65 | Data read from the memory |
| exp_data | input | 65 | Expected data |
| bit_mask | input | 65 | 1 for each bit position that is compared |
| fail_addr | input | 17 | Physical address of the read |
| mem_idx | input | 3 | Index of the memory under test |
| alg_pass | input | 4 | Current algorithm pass, 1-based |
| pattern | input | 6 | Current pattern code |
| seed | input | 4 | Data seed currently in effect |
| fail | output | 1 | Fail flag |
| fail_map | output | 8 | Per-memory failure bitmap |
| log_addr | output | 17 | Address at the first failure |
| log_bits | output | 65 | Masked XOR at the first failure |
| log_seed | output | 4 | Seed at the first failure |
| log_pass | output | 4 | Pass number at the first failure |
| log_pattern | output | 6 | Pattern code at the first failure |
| log_half | output | 1 | Read half of the first failure |

## Verification
On every cycle the assertions hold the sticky flag up once raised, tie the real-time flag to the previous cycle's miscompare, keep the bitmap from losing bits, keep the frozen detail fields stable after capture, and require a clear to empty everything. Only the bench's scenarios show the captured values themselves: the masked XOR against the applied words, the read-half choice for failures on either side of bit 32, the masking of unused bits, the joint setting of the paired bitmap bits, and the return to sticky mode after reset.

// File: rtl/ffl_pkg.sv
// Shared types for the first-failure datalog unit.
package ffl_pkg;
    // Fail reporting mode held in the mode bit.
    typedef enum logic {
        FM_STICKY   = 1'b0,
        FM_REALTIME = 1'b1
    } fail_mode_e;
endpackage

// File: rtl/ffl_compare.sv
// Masked read comparison. Assumes bit_mask is 1 for compared positions.
// Purely combinational; produces the difference word, the miscompare
// strobe and the read-half indication for the current compare.
module ffl_compare #(
    parameter int DATA_W = 65,
    parameter int HALF_W = 32
) (
    input  logic              cmp_valid,
    input  logic [DATA_W-1:0] rd_data,
    input  logic [DATA_W-1:0] exp_data,
    input  logic [DATA_W-1:0] bit_mask,
    output logic [DATA_W-1:0] diff,
    output logic              miss,
    output logic              hi_half
);
    // Difference restricted to compared bits, and its summary flags.
    always_comb begin
        diff    = (rd_data ^ exp_data) & bit_mask;
        miss    = cmp_valid && (|diff);
        hi_half = ~(|diff[HALF_W-1:0]);
    end
endmodule

// File: rtl/ffl_memmap.sv
// Per-memory failure bitmap. Assumes idx names the memory under test.
// Bits only ever set until clear; the paired memories share failures
// when pair_en is high.
module ffl_memmap #(
    parameter int NUM_MEM = 8,
    parameter int PAIR_LO = 3,
    parameter int PAIR_HI = 4,
    localparam int IDX_W  = $clog2(NUM_MEM)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic               miss,
    input  logic [IDX_W-1:0]   idx,
    input  logic               pair_en,
    output logic [NUM_MEM-1:0] map
);
    logic in_pair;

    // The failing memory belongs to the parallel-tested pair.
    always_comb begin
        in_pair = pair_en && ((idx == IDX_W'(PAIR_LO)) || (idx == IDX_W'(PAIR_HI)));
    end

    for (genvar i = 0; i < NUM_MEM; i++) begin : g_bit
        logic hit;
        logic bit_q;

        // This bit is hit directly or through the pair rule.
        always_comb begin
            hit = (idx == IDX_W'(i)) || (in_pair && ((i == PAIR_LO) || (i == PAIR_HI)));
        end

        // Accumulate failures for memory i.
        always_ff @(posedge clk) begin
            if (!rst_n || clr) bit_q <= 1'b0;
            else if (miss && hit) bit_q <= 1'b1;
        end

        assign map[i] = bit_q;
    end
endmodule

// File: rtl/ffl_capture.sv
// First-failure detail capture. Assumes miss is the masked miscompare
// strobe. Loads the detail fields once and holds them until clear.
module ffl_capture #(
    parameter int DATA_W = 65,
    parameter int ADDR_W = 17,
    parameter int PASS_W = 4,
    parameter int PAT_W  = 6,
    parameter int SEED_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              miss,
    input  logic [DATA_W-1:0] diff,
    input  logic              hi_half,
    input  logic [ADDR_W-1:0] addr,
    input  logic [PASS_W-1:0] pass_no,
    input  logic [PAT_W-1:0]  pat,
    input  logic [SEED_W-1:0] seed,
    output logic              captured,
    output logic [ADDR_W-1:0] log_addr,
    output logic [DATA_W-1:0] log_bits,
    output logic [SEED_W-1:0] log_seed,
    output logic [PASS_W-1:0] log_pass,
    output logic [PAT_W-1:0]  log_pattern,
    output logic              log_half
);
    logic load;

    // Load only on the first miscompare after reset or clear.
    always_comb begin
        load = miss && !captured;
    end

    // Capture flag: set at first failure, cleared by reset or clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) captured <= 1'b0;
        else if (load)     captured <= 1'b1;
    end

    // Detail fields frozen at the first failure.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            log_addr    <= '0;
            log_bits    <= '0;
            log_seed    <= '0;
            log_pass    <= '0;
            log_pattern <= '0;
            log_half    <= 1'b0;
        end else if (load) begin
            log_addr    <= addr;
            log_bits    <= diff;
            log_seed    <= seed;
            log_pass    <= pass_no;
            log_pattern <= pat;
            log_half    <= hi_half;
        end
    end
endmodule

// File: rtl/ffl_failout.sv
// Fail flag generation. Holds the fail-mode bit (sticky after reset)
// and drives fail either sticky or per miscompare cycle.
module ffl_failout
    import ffl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic mode_wr,
    input  logic mode_rt,
    input  logic miss,
    output fail_mode_e mode,
    output logic fail
);
    // Fail-mode bit, loaded by mode_wr.
    always_ff @(posedge clk) begin
        if (!rst_n)       mode <= FM_STICKY;
        else if (mode_wr) mode <= fail_mode_e'(mode_rt);
    end

    // Fail flag per the current mode.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)           fail <= 1'b0;
        else if (mode == FM_REALTIME) fail <= miss;
        else                          fail <= fail | miss;
    end
endmodule

// File: rtl/ffail_log.sv
// First-failure datalog capture unit (top). Assumes the test engine
// presents one comparison per cycle with cmp_valid and holds the
// address, pass, pattern and seed of that compare in the same cycle.
module ffail_log
    import ffl_pkg::*;
#(
    parameter int DATA_W  = 65,
    parameter int HALF_W  = 32,
    parameter int ADDR_W  = 17,
    parameter int NUM_MEM = 8,
    parameter int PASS_W  = 4,
    parameter int PAT_W   = 6,
    parameter int SEED_W  = 4,
    parameter int PAIR_LO = 3,
    parameter int PAIR_HI = 4,
    localparam int IDX_W  = $clog2(NUM_MEM)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic               mode_wr,
    input  logic               mode_rt,
    input  logic               pair_en,
    input  logic               cmp_valid,
    input  logic [DATA_W-1:0]  rd_data,
    input  logic [DATA_W-1:0]  exp_data,
    input  logic [DATA_W-1:0]  bit_mask,
    input  logic [ADDR_W-1:0]  fail_addr,
    input  logic [IDX_W-1:0]   mem_idx,
    input  logic [PASS_W-1:0]  alg_pass,
    input  logic [PAT_W-1:0]   pattern,
    input  logic [SEED_W-1:0]  seed,
    output logic               fail,
    output logic [NUM_MEM-1:0] fail_map,
    output logic [ADDR_W-1:0]  log_addr,
    output logic [DATA_W-1:0]  log_bits,
    output logic [SEED_W-1:0]  log_seed,
    output logic [PASS_W-1:0]  log_pass,
    output logic [PAT_W-1:0]   log_pattern,
    output logic               log_half
);
    logic [DATA_W-1:0] diff_w;
    logic              miss_w;
    logic              hi_w;
    logic              cap_w;
    fail_mode_e        mode_w;

    ffl_compare #(.DATA_W(DATA_W), .HALF_W(HALF_W)) u_cmp (
        .cmp_valid (cmp_valid),
        .rd_data   (rd_data),
        .exp_data  (exp_data),
        .bit_mask  (bit_mask),
        .diff      (diff_w),
        .miss      (miss_w),
        .hi_half   (hi_w)
    );

    ffl_memmap #(.NUM_MEM(NUM_MEM), .PAIR_LO(PAIR_LO), .PAIR_HI(PAIR_HI)) u_map (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (clr),
        .miss    (miss_w),
        .idx     (mem_idx),
        .pair_en (pair_en),
        .map     (fail_map)
    );

    ffl_capture #(
        .DATA_W(DATA_W), .ADDR_W(ADDR_W), .PASS_W(PASS_W),
        .PAT_W(PAT_W), .SEED_W(SEED_W)
    ) u_cap (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr         (clr),
        .miss        (miss_w),
        .diff        (diff_w),
        .hi_half     (hi_w),
        .addr        (fail_addr),
        .pass_no     (alg_pass),
        .pat         (pattern),
        .seed        (seed),
        .captured    (cap_w),
        .log_addr    (log_addr),
        .log_bits    (log_bits),
        .log_seed    (log_seed),
        .log_pass    (log_pass),
        .log_pattern (log_pattern),
        .log_half    (log_half)
    );

    ffl_failout u_fail (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (clr),
        .mode_wr (mode_wr),
        .mode_rt (mode_rt),
        .miss    (miss_w),
        .mode    (mode_w),
        .fail    (fail)
    );
endmodule

// File: rtl/ffl_checker.sv
// Property checker for ffail_log, attached by bind below.
module ffl_checker #(
    parameter int NUM_MEM = 8,
    parameter int ADDR_W  = 17,
    parameter int DATA_W  = 65,
    parameter int SEED_W  = 4,
    parameter int PASS_W  = 4,
    parameter int PAT_W   = 6
) (
    input logic               clk,
    input logic               rst_n,
    input logic               clr,
    input logic               mode_wr,
    input logic               mode_bit,
    input logic               miss,
    input logic               captured,
    input logic               fail,
    input logic [NUM_MEM-1:0] fail_map,
    input logic [ADDR_W-1:0]  log_addr,
    input logic [DATA_W-1:0]  log_bits,
    input logic [SEED_W-1:0]  log_seed,
    input logic [PASS_W-1:0]  log_pass,
    input logic [PAT_W-1:0]   log_pattern
);
    // R1: a clear empties the bitmap, the fail flag and the capture.
    a_r1_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (fail_map == '0) && !fail && !captured);

    // R3: in sticky mode a raised fail stays raised.
    a_r3_sticky_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (fail && !mode_bit && !mode_wr && !clr) |=> fail);

    // R4: in real-time mode fail follows the previous miscompare.
    a_r4_realtime_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_bit && !mode_wr && !clr) |=> (fail == $past(miss)));

    // R5: captured detail fields do not move until clear.
    a_r5_detail_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (captured && !clr) |=> ($stable(log_addr) && $stable(log_bits) &&
                                $stable(log_seed) && $stable(log_pass) &&
                                $stable(log_pattern)));

    // R6: bitmap bits are never lost without a clear.
    a_r6_map_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> ((fail_map & $past(fail_map)) == $past(fail_map)));
endmodule

bind ffail_log ffl_checker #(
    .NUM_MEM(NUM_MEM), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .SEED_W(SEED_W), .PASS_W(PASS_W), .PAT_W(PAT_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .clr         (clr),
    .mode_wr     (mode_wr),
    .mode_bit    (mode_w),
    .miss        (miss_w),
    .captured    (cap_w),
    .fail        (fail),
    .fail_map    (fail_map),
    .log_addr    (log_addr),
    .log_bits    (log_bits),
    .log_seed    (log_seed),
    .log_pass    (log_pass),
    .log_pattern (log_pattern)
);

// File: tb/sim_ffail_log.sv
module sim_ffail_log;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clr = 1'b0, mode_wr = 1'b0, mode_rt = 1'b0, pair_en = 1'b0;
    logic        cmp_valid = 1'b0;
    logic [64:0] rd_data = '0, exp_data = '0, bit_mask = '1;
    logic [16:0] fail_addr = '0;
    logic [2:0]  mem_idx = '0;
    logic [3:0]  alg_pass = '0;
    logic [5:0]  pattern = '0;
    logic [3:0]  seed = '0;
    logic        fail;
    logic [7:0]  fail_map;
    logic [16:0] log_addr;
    logic [64:0] log_bits;
    logic [3:0]  log_seed, log_pass;
    logic [5:0]  log_pattern;
    logic        log_half;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    ffail_log u0 (.*);

    typedef struct packed {
        logic [64:0] rd;
        logic [64:0] ex;
        logic [64:0] mk;
        logic [2:0]  idx;
        logic        efail;
        logic        ehalf;
    } vec_t;

    localparam logic [64:0] ONE = 65'd1;
    localparam vec_t VT [6] = '{
        '{65'h0_1234_5678_9ABC_DEF0, 65'h0_1234_5678_9ABC_DEF0, '1, 3'd0, 1'b0, 1'b0},
        '{ONE,                       65'd0,                     '1, 3'd1, 1'b1, 1'b0},
        '{ONE << 40,                 65'd0,                     '1, 3'd2, 1'b1, 1'b1},
        '{ONE << 64,                 65'd0,                     ~(ONE << 64), 3'd5, 1'b0, 1'b0},
        '{(ONE << 5) | (ONE << 50),  65'd0,                     '1, 3'd6, 1'b1, 1'b0},
        '{65'h1_FFFF_FFFF_0000_0000, 65'h1_FFFF_FFFE_0000_0000, '1, 3'd7, 1'b1, 1'b1}
    };

    task automatic chk(input bit ok, input string req, input logic [64:0] act, input logic [64:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One compare cycle driven at the falling edge; returns at the next falling edge.
    task automatic cmp(input logic [64:0] rd, input logic [64:0] ex, input logic [64:0] mk,
                       input logic [2:0] idx, input logic [16:0] ad, input logic [3:0] ps,
                       input logic [5:0] pt, input logic [3:0] sd);
        rd_data = rd; exp_data = ex; bit_mask = mk; mem_idx = idx;
        fail_addr = ad; alg_pass = ps; pattern = pt; seed = sd; cmp_valid = 1'b1;
        @(negedge clk);
        cmp_valid = 1'b0;
    endtask

    task automatic do_clear();
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(!fail && fail_map == 0, "R1 reset fail/map", {fail_map, fail}, 0);
        chk(log_addr == 0 && log_bits == 0 && log_pass == 0 && log_seed == 0 &&
            log_pattern == 0 && !log_half, "R1 reset log", log_bits, 0);

        // Vector walk in sticky mode: R2 masking, R5 bits, R6 map, R8 half
        for (int v = 0; v < 6; v++) begin
            do_clear();
            cmp(VT[v].rd, VT[v].ex, VT[v].mk, VT[v].idx, 17'(v), 4'd2, 6'h03, 4'h5);
            chk(fail == VT[v].efail, "R2 miscompare detect", fail, VT[v].efail);
            chk(log_bits == ((VT[v].rd ^ VT[v].ex) & VT[v].mk), "R5 log_bits masked xor",
                log_bits, (VT[v].rd ^ VT[v].ex) & VT[v].mk);
            chk(log_half == VT[v].ehalf, "R8 read half", log_half, VT[v].ehalf);
            chk(fail_map == (VT[v].efail ? 8'(1) << VT[v].idx : 8'd0), "R6 map bit",
                fail_map, VT[v].efail ? 8'(1) << VT[v].idx : 8'd0);
        end

        // R3 sticky hold, R5 freeze, R6 accumulate
        do_clear();
        cmp(ONE << 3, 0, '1, 3'd2, 17'h1ABCD, 4'd4, 6'h23, 4'hA);
        idle(3);
        chk(fail, "R3 sticky after idle", fail, 1);
        cmp(ONE << 60, 0, '1, 3'd6, 17'h00042, 4'd2, 6'h0F, 4'h1);
        chk(log_addr == 17'h1ABCD && log_pass == 4'd4 && log_pattern == 6'h23 &&
            log_seed == 4'hA && log_bits == (ONE << 3), "R5 fields frozen", log_addr, 17'h1ABCD);
        chk(fail_map == 8'h44, "R6 accumulate", fail_map, 8'h44);
        cmp(0, 0, '1, 3'd6, 0, 0, 0, 0);
        chk(fail, "R3 sticky after clean compare", fail, 1);

        // R9 load real-time mode, R4 per-cycle fail
        do_clear();
        mode_rt = 1'b1; mode_wr = 1'b1;
        @(negedge clk);
        mode_wr = 1'b0;
        cmp(ONE, 0, '1, 3'd1, 0, 4'd2, 0, 0);
        chk(fail, "R4 realtime fail on miss", fail, 1);
        cmp(0, 0, '1, 3'd1, 0, 4'd2, 0, 0);
        chk(!fail, "R9 realtime drops after clean", fail, 0);
        cmp(ONE << 1, 0, ~(ONE << 1), 3'd1, 0, 4'd2, 0, 0);
        chk(!fail, "R4 masked bit no fail", fail, 0);

        // R7 pair sharing
        do_clear();
        pair_en = 1'b1;
        cmp(ONE, 0, '1, 3'd4, 0, 4'd2, 0, 0);
        chk(fail_map == 8'h18, "R7 pair sets both", fail_map, 8'h18);
        do_clear();
        pair_en = 1'b0;
        cmp(ONE, 0, '1, 3'd4, 0, 4'd2, 0, 0);
        chk(fail_map == 8'h10, "R7 no pair one bit", fail_map, 8'h10);

        // R1 clear empties everything
        do_clear();
        chk(!fail && fail_map == 0 && log_bits == 0 && log_addr == 0, "R1 clear", fail_map, 0);

        // R1 reset returns to sticky mode
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        cmp(ONE, 0, '1, 3'd0, 0, 4'd2, 0, 0);
        idle(2);
        chk(fail, "R1 reset restores sticky", fail, 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule